// File: doc/BRIEF.md
# Dual-Path DAC Word Loader

This block collects the 14-bit code for a digital-to-analog converter and holds it in two register stages. The code arrives either as a 16-bit serial frame on three pins or over a 14-bit parallel bus. A mode input picks which path is live. The serial pins are asynchronous to the system clock. They pass through a synchronizer, and the falling edges of the serial clock are detected in the system-clock domain.

In serial mode, two static select inputs set two things. The first is whether the data is sent most-significant-bit first or least-significant-bit first. The second is whether the two filler bits of the frame come before or after the 14 data bits. A completed frame writes the first register stage, called the input word, and produces a one-cycle `frame_done` pulse. A frame that is cut short leaves the input word as it was.

An active-high hold input gates the copy from the input word to the second stage. The second stage drives the converter code `dac_code`. This lets several converters be loaded one after another and then updated together.

Top module: `dac_word_loader`

## Requirements
- R1: A synchronous active-high `rst` clears `dac_code` and the input word to zero, holds `frame_done` low, and abandons any serial frame in progress.
- R2: In serial mode, a frame begins while `fs_n` is low. Each falling edge of `sclk` captures `sdata`. The 16th captured bit completes the frame. Each serial pin passes through SYNC_STAGES flip-flops (default 2), and a falling edge is recognised one system cycle after the synchronized clock has gone low.
- R3: With `fmt_msb_first`=0 and `pad_last`=0, frame bits 1 and 2 are filler, bit 3 is code bit 0, and bit 16 is code bit 13.
- R4: With `fmt_msb_first`=0 and `pad_last`=1, bit 1 is code bit 0, bit 14 is code bit 13, and bits 15 and 16 are filler.
- R5: With `fmt_msb_first`=1 and `pad_last`=0, bits 1 and 2 are filler, bit 3 is code bit 13, and bit 16 is code bit 0.
- R6: With `fmt_msb_first`=1 and `pad_last`=1, bit 1 is code bit 13, bit 14 is code bit 0, and bits 15 and 16 are filler.
- R7: If `fs_n` rises before the 16th falling edge, the partial frame is dropped and the input word keeps its value.
- R8: `frame_done` is high for exactly one system cycle: the cycle in which a complete frame is written to the input word. Further `sclk` edges after the 16th do nothing until `fs_n` has gone high and then low again.
- R9: In parallel mode (`ser_mode`=0), the input word takes `par_data` on every clock edge at which both `par_cs_n` and `par_wr_n` are low. It holds while either of them is high.
- R10: At each clock edge where `upd_hold` is low, `dac_code` takes the input word as it stood before that edge, so it follows one cycle later. While `upd_hold` is high, `dac_code` does not change.
- R11: In parallel mode, serial pin activity has no effect and `frame_done` stays low. In serial mode (`ser_mode`=1), the parallel bus has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_mode | input | 1 | 1 = serial path, 0 = parallel path |
| fs_n | input | 1 | Serial frame sync, active low (asynchronous) |
| sclk | input | 1 | Serial bit clock; data is captured on its falling edge (asynchronous) |
| sdata | input | 1 | Serial data (asynchronous) |
| fmt_msb_first | input | 1 | 1 = most significant bit sent first |
| pad_last | input | 1 | 1 = the two filler bits end the frame, 0 = they start it |
| par_cs_n | input | 1 | Parallel select, active low |
| par_wr_n | input | 1 | Parallel write, active low |
| par_data | input | DATA_W | Parallel code bus |
| upd_hold | input | 1 | High blocks the copy into the output stage |
| dac_code | output | DATA_W | Converter code from the output stage |
| frame_done | output | 1 | One-cycle pulse when a serial frame loads the input word |

## Verification
The bench builds the block with its default values: a 14-bit code, a 16-bit frame and a two-stage synchronizer. Its reference model delays the serial pins by the synchronizer depth, taken from the bench parameter. Frames are sent with serial half-periods of three system cycles and of one system cycle. The short half-period reaches the tightest edge spacing the detector must still resolve. With these sizes the bench covers all four layouts, frames cut short at an odd bit count, extra clock edges past the 16th, and both kinds of mode crossing.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;

  // Serial layout selected by {fmt_msb_first, pad_last}
  typedef enum logic [1:0] {
    LAY_LSB_LATE  = 2'b00,  // filler first, data LSB-first
    LAY_LSB_EARLY = 2'b01,  // data LSB-first, filler last
    LAY_MSB_LATE  = 2'b10,  // filler first, data MSB-first
    LAY_MSB_EARLY = 2'b11   // data MSB-first, filler last
  } frame_layout_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pin_s
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign pin_s = chain[STAGES-1];

endmodule

// File: rtl/serial_framer.sv
module serial_framer
  import dac_loader_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int FRAME_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fs_n_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              msb_first,
  input  logic              pad_last,
  output logic              load,
  output logic [DATA_W-1:0] word
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_LEN);

  logic                 sclk_q;
  logic                 fall;
  logic                 active;
  logic [CNT_W-1:0]     cnt;
  logic [FRAME_LEN-2:0] shreg;
  logic [FRAME_LEN-1:0] full;
  logic [DATA_W-1:0]    picked;
  logic [DATA_W-1:0]    flipped;
  frame_layout_e        layout;

  assign fall   = sclk_q & ~sclk_s;
  assign active = en & ~fs_n_s;
  assign full   = {shreg, sdata_s};
  assign load   = active & fall & (cnt == LAST_IDX);
  assign layout = frame_layout_e'({msb_first, pad_last});

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  // bit counter: cleared whenever the frame is not live, saturates at FRAME_LEN
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (fall && cnt != FULL_CNT) begin
      cnt   <= cnt + 1'b1;
      shreg <= full[FRAME_LEN-2:0];
    end
  end

  // full[FRAME_LEN-1] is the first bit received
  always_comb begin
    for (int i = 0; i < DATA_W; i++) flipped[i] = picked[DATA_W-1-i];
  end

  always_comb begin
    picked = full[DATA_W-1:0];
    word   = '0;
    unique case (layout)
      LAY_LSB_LATE: begin
        picked = full[DATA_W-1:0];
        word   = flipped;
      end
      LAY_LSB_EARLY: begin
        picked = full[FRAME_LEN-1 -: DATA_W];
        word   = flipped;
      end
      LAY_MSB_LATE: begin
        picked = full[DATA_W-1:0];
        word   = picked;
      end
      LAY_MSB_EARLY: begin
        picked = full[FRAME_LEN-1 -: DATA_W];
        word   = picked;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/word_latch_pair.sv
module word_latch_pair #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              hold,
  output logic [DATA_W-1:0] in_word,
  output logic [DATA_W-1:0] out_code
);

  always_ff @(posedge clk) begin
    if (rst)       in_word <= '0;
    else if (load) in_word <= load_word;
  end

  always_ff @(posedge clk) begin
    if (rst)        out_code <= '0;
    else if (!hold) out_code <= in_word;
  end

endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader #(
  parameter int DATA_W      = 14,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic              fs_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              fmt_msb_first,
  input  logic              pad_last,
  input  logic              par_cs_n,
  input  logic              par_wr_n,
  input  logic [DATA_W-1:0] par_data,
  input  logic              upd_hold,
  output logic [DATA_W-1:0] dac_code,
  output logic              frame_done
);

  logic              fs_n_s, sclk_s, sdata_s;
  logic              ser_load, par_load, any_load;
  logic [DATA_W-1:0] ser_word, load_word, in_word;

  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_fs (
    .clk(clk), .rst(rst), .pin(fs_n), .pin_s(fs_n_s)
  );
  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .pin(sclk), .pin_s(sclk_s)
  );
  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdata (
    .clk(clk), .rst(rst), .pin(sdata), .pin_s(sdata_s)
  );

  serial_framer #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .en        (ser_mode),
    .fs_n_s    (fs_n_s),
    .sclk_s    (sclk_s),
    .sdata_s   (sdata_s),
    .msb_first (fmt_msb_first),
    .pad_last  (pad_last),
    .load      (ser_load),
    .word      (ser_word)
  );

  assign par_load  = ~ser_mode & ~par_cs_n & ~par_wr_n;
  assign any_load  = ser_load | par_load;
  assign load_word = ser_mode ? ser_word : par_data;

  word_latch_pair #(.DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .load      (any_load),
    .load_word (load_word),
    .hold      (upd_hold),
    .in_word   (in_word),
    .out_code  (dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst) frame_done <= 1'b0;
    else     frame_done <= ser_load;
  end

endmodule

// File: rtl/dac_word_loader_chk.sv
module dac_word_loader_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_mode,
  input logic              par_cs_n,
  input logic              par_wr_n,
  input logic              upd_hold,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] dac_code,
  input logic              frame_done
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R11
  done_mode_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(ser_mode));

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    upd_hold |=> $stable(dac_code));

  // R10
  code_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_hold |=> (dac_code == $past(in_word)));

  // R2
  ser_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ser_mode) && !$past(rst) && !$stable(in_word)) |-> frame_done);

  // R9
  par_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(ser_mode) && !$past(rst) && !$stable(in_word))
      |-> (!$past(par_cs_n) && !$past(par_wr_n)));

endmodule

bind dac_word_loader dac_word_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ser_mode   (ser_mode),
  .par_cs_n   (par_cs_n),
  .par_wr_n   (par_wr_n),
  .upd_hold   (upd_hold),
  .in_word    (in_word),
  .dac_code   (dac_code),
  .frame_done (frame_done)
);

// File: tb/test_dac_word_loader.sv
module test_dac_word_loader;

  localparam int CLK_P = 10;
  localparam int DW    = 14;
  localparam int FL    = 16;
  localparam int SYNC  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_mode = 1'b1;
  logic          fs_n = 1'b1;
  logic          sclk = 1'b0;
  logic          sdata = 1'b0;
  logic          fmt_msb_first = 1'b0;
  logic          pad_last = 1'b0;
  logic          par_cs_n = 1'b1;
  logic          par_wr_n = 1'b1;
  logic [DW-1:0] par_data = '0;
  logic          upd_hold = 1'b0;
  logic [DW-1:0] dac_code;
  logic          frame_done;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    pulses   = 0;
  bit    finished = 0;
  string cur_req  = "R1";

  always #(CLK_P/2) clk = ~clk;

  dac_word_loader #(.DATA_W(DW), .FRAME_LEN(FL), .SYNC_STAGES(SYNC)) i_dac_word_loader (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .fs_n(fs_n), .sclk(sclk),
    .sdata(sdata), .fmt_msb_first(fmt_msb_first), .pad_last(pad_last),
    .par_cs_n(par_cs_n), .par_wr_n(par_wr_n), .par_data(par_data),
    .upd_hold(upd_hold), .dac_code(dac_code), .frame_done(frame_done)
  );

  // ---------------- reference model ----------------
  logic [2:0]    hist[$];          // {fs_n, sclk, sdata} per edge, newest first
  int            m_cnt = 0;
  logic [FL-1:0] m_bits = '0;      // m_bits[k-1] = frame bit k
  logic [DW-1:0] m_in = '0, m_out = '0;
  logic          m_done = 1'b0;

  function automatic logic [DW-1:0] decode(logic [FL-1:0] b, logic msb, logic pad);
    logic [DW-1:0] w;
    int first = pad ? 1 : 3;
    for (int j = 0; j < DW; j++) begin
      if (msb) w[DW-1-j] = b[first-1+j];
      else     w[j]      = b[first-1+j];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    logic [2:0] now_v, prv_v;
    if (rst) begin
      hist.delete();
      m_cnt = 0; m_bits = '0; m_in = '0; m_out = '0; m_done = 1'b0;
    end else begin
      hist.push_front({fs_n, sclk, sdata});
      if (hist.size() > 8) void'(hist.pop_back());
      now_v = (hist.size() > SYNC)     ? hist[SYNC]     : 3'b100;
      prv_v = (hist.size() > SYNC + 1) ? hist[SYNC + 1] : 3'b100;
      if (!upd_hold) m_out = m_in;
      m_done = 1'b0;
      if (ser_mode) begin
        if (now_v[2]) begin
          m_cnt = 0; m_bits = '0;
        end else if (prv_v[1] && !now_v[1] && m_cnt < FL) begin
          m_bits[m_cnt] = now_v[0];
          m_cnt++;
          if (m_cnt == FL) begin
            m_in   = decode(m_bits, fmt_msb_first, pad_last);
            m_done = 1'b1;
          end
        end
      end else begin
        m_cnt = 0; m_bits = '0;
        if (!par_cs_n && !par_wr_n) m_in = par_data;
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(dac_code === m_out, cur_req, "dac_code vs model", 32'(dac_code), 32'(m_out));
      check(frame_done === m_done, cur_req, "frame_done vs model", 32'(frame_done), 32'(m_done));
      if (frame_done === 1'b1) pulses++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [FL-1:0] build(logic [DW-1:0] w, logic msb, logic pad, logic [1:0] junk);
    logic [FL-1:0] f;     // f[k-1] = frame bit k
    int first = pad ? 1 : 3;
    f = '0;
    if (pad) begin f[14] = junk[0]; f[15] = junk[1]; end
    else     begin f[0]  = junk[0]; f[1]  = junk[1]; end
    for (int j = 0; j < DW; j++) f[first-1+j] = msb ? w[DW-1-j] : w[j];
    return f;
  endfunction

  task automatic send(logic [FL-1:0] f, int nbits, int half);
    @(negedge clk);
    fs_n = 1'b0;
    wait_cyc(2);
    for (int k = 0; k < nbits; k++) begin
      sclk = 1'b1; sdata = (k < FL) ? f[k] : ~sdata;
      wait_cyc(half);
      sclk = 1'b0;
      wait_cyc(half);
    end
    wait_cyc(2);
    fs_n = 1'b1;
    wait_cyc(SYNC + 4);
  endtask

  task automatic frame_test(string req, logic [DW-1:0] w, logic msb, logic pad, int half);
    int p0;
    cur_req = req;
    fmt_msb_first = msb; pad_last = pad;
    p0 = pulses;
    send(build(w, msb, pad, 2'b11), FL, half);
    check(dac_code === w, req, "code after frame", 32'(dac_code), 32'(w));
    check(pulses - p0 == 1, "R8", "frame_done pulses", 32'(pulses - p0), 32'd1);
  endtask

  initial begin
    int p0;
    logic [DW-1:0] keep;
    wait_cyc(3);
    cur_req = "R1";
    check(dac_code === '0, "R1", "reset code", 32'(dac_code), 32'd0);
    check(frame_done === 1'b0, "R1", "reset done", 32'(frame_done), 32'd0);
    rst = 1'b0;
    wait_cyc(4);

    frame_test("R3", 14'h2A5C, 1'b0, 1'b0, 3);
    frame_test("R3", 14'h0001, 1'b0, 1'b0, 3);
    frame_test("R4", 14'h1B37, 1'b0, 1'b1, 3);
    frame_test("R4", 14'h2000, 1'b0, 1'b1, 3);
    frame_test("R5", 14'h0F0F, 1'b1, 1'b0, 3);
    frame_test("R5", 14'h3FFE, 1'b1, 1'b0, 3);
    frame_test("R6", 14'h1234, 1'b1, 1'b1, 3);
    frame_test("R6", 14'h0003, 1'b1, 1'b1, 3);
    frame_test("R2", 14'h3C69, 1'b1, 1'b0, 1);
    frame_test("R2", 14'h0A5A, 1'b0, 1'b1, 1);

    // R8: extra edges after the 16th are ignored
    cur_req = "R8";
    p0 = pulses;
    fmt_msb_first = 1'b1; pad_last = 1'b1;
    send(build(14'h1111, 1'b1, 1'b1, 2'b00), FL + 3, 2);
    check(dac_code === 14'h1111, "R8", "code after long frame", 32'(dac_code), 32'h1111);
    check(pulses - p0 == 1, "R8", "one pulse for long frame", 32'(pulses - p0), 32'd1);

    // R7: aborted frame
    cur_req = "R7";
    p0 = pulses;
    send(build(14'h2222, 1'b1, 1'b1, 2'b00), 11, 2);
    check(dac_code === 14'h1111, "R7", "code after abort", 32'(dac_code), 32'h1111);
    check(pulses - p0 == 0, "R7", "no pulse on abort", 32'(pulses - p0), 32'd0);
    frame_test("R7", 14'h0555, 1'b1, 1'b1, 2);

    // R10: hold blocks transfer
    cur_req = "R10";
    upd_hold = 1'b1;
    send(build(14'h3333, 1'b1, 1'b1, 2'b10), FL, 2);
    check(dac_code === 14'h0555, "R10", "code held", 32'(dac_code), 32'h0555);
    upd_hold = 1'b0;
    wait_cyc(2);
    check(dac_code === 14'h3333, "R10", "code after release", 32'(dac_code), 32'h3333);

    // R11: parallel writes ignored in serial mode
    cur_req = "R11";
    par_data = 14'h0F00; par_cs_n = 1'b0; par_wr_n = 1'b0;
    wait_cyc(3);
    par_cs_n = 1'b1; par_wr_n = 1'b1;
    wait_cyc(2);
    check(dac_code === 14'h3333, "R11", "parallel ignored in serial", 32'(dac_code), 32'h3333);

    // R9: parallel mode
    cur_req = "R9";
    ser_mode = 1'b0;
    par_data = 14'h1ABC; par_cs_n = 1'b0; par_wr_n = 1'b0;
    wait_cyc(1);
    par_data = 14'h2DEF;
    wait_cyc(1);
    par_wr_n = 1'b1;
    par_data = 14'h0777;
    wait_cyc(3);
    check(dac_code === 14'h2DEF, "R9", "bus followed then held", 32'(dac_code), 32'h2DEF);
    par_wr_n = 1'b0; par_cs_n = 1'b1;
    wait_cyc(3);
    check(dac_code === 14'h2DEF, "R9", "cs high blocks", 32'(dac_code), 32'h2DEF);
    par_cs_n = 1'b1; par_wr_n = 1'b1;

    // R11: serial activity ignored in parallel mode
    cur_req = "R11";
    p0 = pulses;
    send(build(14'h0101, 1'b1, 1'b1, 2'b00), FL, 2);
    check(dac_code === 14'h2DEF, "R11", "serial ignored in parallel", 32'(dac_code), 32'h2DEF);
    check(pulses - p0 == 0, "R11", "no pulse in parallel", 32'(pulses - p0), 32'd0);

    // R1: reset mid-run
    cur_req = "R1";
    keep = dac_code;
    rst = 1'b1;
    wait_cyc(2);
    check(dac_code === '0, "R1", "code after reset", 32'(dac_code), 32'd0);
    rst = 1'b0;
    ser_mode = 1'b1;
    wait_cyc(3);
    check(dac_code === '0 && keep !== '0, "R1", "code stays cleared", 32'(dac_code), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule